// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block takes the clock and data lines of a PS/2 keyboard and turns each serial frame into one scan code. It queues the codes for a downstream consumer. Both lines first pass through synchronizers. Each falling edge of the synchronized keyboard clock moves a four-state frame machine along. The states are idle, data bits, parity and stop, encoded 0, 1, 2 and 3.

An inactivity timer is driven by a one-microsecond tick. If a frame stops partway, the timer throws the partial frame away, so the next frame always starts clean. Frames that pass the checks are written into a circular buffer at a write pointer. A consumer reads them at a read pointer through a valid/ready pair.

Top module: `kbd_frame_rx`

## Requirements
- R1: While reset is held and in the first cycle after it, `codeValid` is low and the buffer is empty.
- R2: A frame is one start bit at 0, then eight data bits least significant bit first, then a parity bit, then a stop bit. Each bit is sampled on a falling edge of the keyboard clock. A valid frame delivers its eight data bits as `codeData`.
- R3: In the idle state, a falling clock edge that finds the data line high is ignored, and the receiver stays idle.
- R4: The eight data bits and the parity bit together must hold an odd number of ones. A frame that fails this check is dropped.
- R5: The stop bit must be 1. If it is 0, the frame is dropped and the receiver returns to idle.
- R6: Suppose `TIMEOUT_TICKS` pulses of `usTick` pass with no keyboard clock falling edge while a frame is in progress. Then the receiver returns to idle and drops the partial frame.
- R7: The buffer holds `DEPTH` codes in arrival order. A code that completes while the buffer is full is discarded.
- R8: `codeValid` is high exactly when the buffer is not empty. A code is consumed on a clock edge where `codeValid` and `codeReady` are both high. While the consumer stalls, `codeValid` and `codeData` hold.
- R9: A code becomes visible on the outputs three clock edges after the keyboard clock falls for its stop bit: two synchronizer stages plus the buffer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse every microsecond |
| kbdClk | input | 1 | Keyboard clock line (asynchronous) |
| kbdData | input | 1 | Keyboard data line (asynchronous) |
| codeReady | input | 1 | Consumer accepts the offered code |
| codeValid | output | 1 | A scan code is available |
| codeData | output | DATA_W | Oldest scan code in the buffer |

## Verification
The bench builds the block with `TIMEOUT_TICKS` set to 16 and pulses `usTick` every fourth clock. A stalled frame therefore times out in about 64 cycles, while the gap between two bits of a healthy frame stays near ten cycles, well inside the limit. `DEPTH` keeps its default of 16. This lets eighteen back-to-back frames with the consumer stalled overrun the buffer, so the drop of extra codes and the drain afterwards can be observed. Frames with bad parity, a bad stop bit, an abandoned frame and a stray idle clock pulse are mixed among good frames. The consumer's ready pattern switches between always on, always off and throttled.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_PARITY = 2'd2,
    ST_STOP   = 2'd3
  } rxState_e;

  typedef struct packed {
    logic shiftIn;
    logic clearAll;
    logic pushCode;
  } rxStrobe_t;
endpackage

// File: rtl/kbd_rx_sync.sv
module kbd_rx_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] rawIn,
  output logic [LINES-1:0] syncOut
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawIn[i]};
    end
    assign syncOut[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl
  import kbd_rx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_TICKS = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      usTick,
  input  logic      fallEdge,
  input  logic      dataBit,
  input  logic      parityOdd,
  output rxState_e  frameState,
  output rxStrobe_t strobe
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int TMR_W = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_TICKS - 1);

  rxState_e         state, stateNext;
  logic [CNT_W-1:0] bitCnt;
  logic [TMR_W-1:0] idleTmr;
  logic             parityOk;
  logic             timeoutHit;

  assign timeoutHit = !fallEdge && (state != ST_IDLE) && usTick && (idleTmr == TMR_LAST);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (timeoutHit) begin
      stateNext       = ST_IDLE;
      strobe.clearAll = 1'b1;
    end else if (fallEdge) begin
      unique case (state)
        ST_IDLE:   if (!dataBit) stateNext = ST_DATA;
        ST_DATA: begin
          strobe.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) stateNext = ST_PARITY;
        end
        ST_PARITY: stateNext = ST_STOP;
        ST_STOP: begin
          strobe.pushCode = dataBit && parityOk;
          stateNext       = ST_IDLE;
        end
        default:   stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      idleTmr  <= '0;
      parityOk <= 1'b0;
    end else begin
      state <= stateNext;
      if (fallEdge) idleTmr <= '0;
      else if (timeoutHit) idleTmr <= '0;
      else if (usTick && state != ST_IDLE) idleTmr <= idleTmr + 1'b1;

      if (strobe.clearAll || (fallEdge && state == ST_IDLE)) bitCnt <= '0;
      else if (strobe.shiftIn) bitCnt <= bitCnt + 1'b1;

      if (strobe.clearAll) parityOk <= 1'b0;
      else if (fallEdge && state == ST_PARITY) parityOk <= parityOdd;
    end
  end

  assign frameState = state;
endmodule

// File: rtl/kbd_rx_dpath.sv
module kbd_rx_dpath
  import kbd_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkSync,
  input  logic              dataSync,
  input  rxStrobe_t         strobe,
  input  logic              codeReady,
  output logic              fallEdge,
  output logic              parityOdd,
  output logic              bufFull,
  output logic              codeValid,
  output logic [DATA_W-1:0] codeData
);
  localparam int PTR_W = $clog2(DEPTH);

  logic              clkPrev;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W:0]    wrPtr, rdPtr;
  logic              bufEmpty, doWrite, doRead;

  assign fallEdge  = clkPrev && !clkSync;
  assign parityOdd = ^{shiftReg, dataSync};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPrev  <= 1'b1;
      shiftReg <= '0;
    end else begin
      clkPrev <= clkSync;
      if (strobe.clearAll)     shiftReg <= '0;
      else if (strobe.shiftIn) shiftReg <= {dataSync, shiftReg[DATA_W-1:1]};
    end
  end

  assign bufEmpty = (wrPtr == rdPtr);
  assign bufFull  = (wrPtr[PTR_W] != rdPtr[PTR_W]) &&
                    (wrPtr[PTR_W-1:0] == rdPtr[PTR_W-1:0]);
  assign doWrite  = strobe.pushCode && !bufFull;
  assign doRead   = codeReady && !bufEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doWrite) wrPtr <= wrPtr + 1'b1;
      if (doRead)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr[PTR_W-1:0]] <= shiftReg;
  end

  assign codeValid = !bufEmpty;
  assign codeData  = mem[rdPtr[PTR_W-1:0]];
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_rx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_TICKS = 100,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              kbdClk,
  input  logic              kbdData,
  input  logic              codeReady,
  output logic              codeValid,
  output logic [DATA_W-1:0] codeData
);
  logic [1:0] lineSync;
  logic       clkSync, dataSync;
  logic       fallEdge, parityOdd, bufFull;
  rxState_e   frameState;
  rxStrobe_t  strobe;

  kbd_rx_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .rawIn({kbdData, kbdClk}), .syncOut(lineSync)
  );
  assign clkSync  = lineSync[0];
  assign dataSync = lineSync[1];

  kbd_rx_ctrl #(.DATA_W(DATA_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .fallEdge(fallEdge),
    .dataBit(dataSync), .parityOdd(parityOdd),
    .frameState(frameState), .strobe(strobe)
  );

  kbd_rx_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .clkSync(clkSync), .dataSync(dataSync),
    .strobe(strobe), .codeReady(codeReady), .fallEdge(fallEdge),
    .parityOdd(parityOdd), .bufFull(bufFull),
    .codeValid(codeValid), .codeData(codeData)
  );
endmodule

// File: rtl/kbd_rx_chk.sv
module kbd_rx_chk #(
  parameter int DATA_W        = 8,
  parameter int TIMEOUT_TICKS = 100
) (
  input logic              clk,
  input logic              rstN,
  input logic              usTick,
  input logic              codeValid,
  input logic              codeReady,
  input logic [DATA_W-1:0] codeData,
  input logic              fallEdge,
  input logic              dataSync,
  input logic [1:0]        frameState,
  input logic              bufFull
);
  localparam int GAP_W = $clog2(TIMEOUT_TICKS + 2);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(TIMEOUT_TICKS);
  logic [GAP_W-1:0] gapTicks;

  always_ff @(posedge clk) begin
    if (!rstN) gapTicks <= '0;
    else if (fallEdge) gapTicks <= '0;
    else if (usTick && gapTicks < GAP_LIM) gapTicks <= gapTicks + 1'b1;
  end

  // R1
  reset_empty_chk: assert property (@(posedge clk) !rstN |=> !codeValid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    codeValid && !codeReady |=> codeValid && $stable(codeData));

  // R7
  full_offers_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> codeValid);

  // R2
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge && frameState == 2'd3 |=> frameState == 2'd0);

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge && dataSync && frameState == 2'd0 |=> frameState == 2'd0);

  // R6
  timeout_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapTicks >= GAP_LIM |-> frameState == 2'd0);
endmodule

bind kbd_frame_rx kbd_rx_chk #(.DATA_W(DATA_W), .TIMEOUT_TICKS(TIMEOUT_TICKS)) chk_i (
  .clk(clk), .rstN(rstN), .usTick(usTick), .codeValid(codeValid),
  .codeReady(codeReady), .codeData(codeData), .fallEdge(fallEdge),
  .dataSync(dataSync), .frameState(frameState), .bufFull(bufFull)
);

// File: tb/kbd_frame_rx_tb.sv
module kbd_frame_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int DEPTH      = 16;
  localparam int TMO        = 16;
  localparam int HALF       = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0;
  logic kbdClk = 1'b1;
  logic kbdData = 1'b1;
  logic codeReady = 1'b0;
  logic codeValid;
  logic [DATA_W-1:0] codeData;

  int compared = 0;
  int mismatched = 0;
  int readyMode = 0;
  int pendReq = 0;
  int pendAck = 0;
  logic [DATA_W-1:0] pendCode = '0;
  logic [DATA_W-1:0] model [$];
  string curReq = "R1";
  bit checking = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_frame_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TIMEOUT_TICKS(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .usTick(usTick), .kbdClk(kbdClk), .kbdData(kbdData),
    .codeReady(codeReady), .codeValid(codeValid), .codeData(codeData)
  );

  // tick and consumer pattern, driven away from the active edge
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    usTick    <= (cyc % 4 == 0);
    codeReady <= (readyMode == 0) ? 1'b1 : (readyMode == 1) ? 1'b0 : (cyc % 3 == 0);
  end

  // behavioural queue model
  always @(posedge clk) begin
    if (!rstN) begin
      model.delete();
      pendAck = pendReq;
    end else begin
      bit wasFull;
      wasFull = (model.size() == DEPTH);
      if (codeReady && model.size() > 0) void'(model.pop_front());
      if (pendReq != pendAck) begin
        if (!wasFull) model.push_back(pendCode);
        pendAck = pendReq;
      end
    end
  end

  // comparison every cycle
  always @(negedge clk) begin
    if (checking) begin
      compared++;
      if (codeValid !== (model.size() > 0)) begin
        mismatched++;
        $display("FAIL %s codeValid actual=%0b expected=%0b", curReq, codeValid, model.size() > 0);
      end else if (codeValid && codeData !== model[0]) begin
        mismatched++;
        $display("FAIL %s codeData actual=%02h expected=%02h", curReq, codeData, model[0]);
      end
    end
  end

  task automatic sendBit(input logic b, input bit isStop, input bit keep, input logic [DATA_W-1:0] code);
    @(negedge clk); kbdData = b;
    repeat (HALF) @(negedge clk);
    kbdClk = 1'b0;
    if (isStop) begin
      @(posedge clk); @(posedge clk); #1;
      if (keep) begin pendCode = code; pendReq++; end
    end
    repeat (HALF) @(negedge clk);
    kbdClk = 1'b1;
  endtask

  task automatic sendFrame(input logic [DATA_W-1:0] code, input bit badPar, input bit badStop);
    logic par;
    par = ~(^code) ^ badPar;
    sendBit(1'b0, 1'b0, 1'b0, code);
    for (int i = 0; i < DATA_W; i++) sendBit(code[i], 1'b0, 1'b0, code);
    sendBit(par, 1'b0, 1'b0, code);
    sendBit(!badStop, 1'b1, !(badPar || badStop), code);
    @(negedge clk); kbdData = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL %s watchdog actual=running expected=finished", curReq);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    compared++;
    if (codeValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset codeValid actual=%0b expected=0", codeValid);
    end
    rstN = 1'b1;
    checking = 1'b1;
    settle(3);

    curReq = "R2/R9";   // LSB-first framing and three-edge latency
    sendFrame(8'h1C, 0, 0);
    sendFrame(8'hA5, 0, 0);
    sendFrame(8'h00, 0, 0);
    sendFrame(8'hFF, 0, 0);
    sendFrame(8'h80, 0, 0);

    curReq = "R4";      // wrong parity dropped
    sendFrame(8'h33, 1, 0);
    sendFrame(8'h34, 0, 0);

    curReq = "R5";      // low stop bit dropped
    sendFrame(8'h55, 0, 1);
    sendFrame(8'h56, 0, 0);

    curReq = "R3";      // stray idle pulse with data high
    @(negedge clk); kbdData = 1'b1; kbdClk = 1'b0;
    settle(HALF); kbdClk = 1'b1; settle(HALF);
    sendFrame(8'h42, 0, 0);

    curReq = "R6";      // abandoned frame then timeout
    sendBit(1'b0, 0, 0, '0);
    for (int i = 0; i < 3; i++) sendBit(1'b1, 0, 0, '0);
    settle(TMO * 4 + 20);
    sendFrame(8'h7E, 0, 0);
    settle(10);

    curReq = "R7";      // overflow with stalled consumer
    readyMode = 1;
    for (int i = 0; i < DEPTH + 2; i++) sendFrame(DATA_W'(8'h10 + i), 0, 0);
    compared++;
    if (codeValid !== 1'b1 || codeData !== 8'h10) begin
      mismatched++;
      $display("FAIL R7 full head actual=%0b/%02h expected=1/10", codeValid, codeData);
    end
    readyMode = 0;
    settle(DEPTH + 4);
    compared++;
    if (codeValid !== 1'b0) begin
      mismatched++;
      $display("FAIL R8 drained codeValid actual=%0b expected=0", codeValid);
    end

    curReq = "R8";      // throttled consumer
    readyMode = 2;
    sendFrame(8'h21, 0, 0);
    sendFrame(8'hE0, 0, 0);
    sendFrame(8'h6B, 0, 0);
    settle(20);
    readyMode = 0;
    settle(10);

    checking = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule